// File: doc/BRIEF.md
# Oversampled Phase-Select Video Capture

This block takes in a parallel digital video bus that runs in step with the pixel clock. The bus carries 12 bits of colour, with 4 bits each for red, green and blue, plus horizontal sync, vertical sync and display-enable. Every input is sampled on each cycle of a fast clock that runs at eight times the pixel rate. A one-cycle strobe marks the first fast cycle of each pixel period, so each period yields eight candidate samples per input bit. At the end of every period, exactly one of the eight samples is forwarded to a registered output. This gives a programmable delay line whose step is one fast-clock period.

The phase can be set by hand or found automatically. In automatic mode the block counts, for each of the eight positions in the period, how often any input bit changes there. The count runs over a window whose length in pixel periods is programmable. At the end of each window the block takes the busiest position and picks the position diametrically opposite it, which is the centre of the stable eye. It adopts that choice only once two windows in a row agree. A parameter gives the sync/enable group its own phase, separate from the colour group, so that skew between the two groups can be corrected.

Top module: `vid_phase_capture`

## Requirements
- R1: After reset, out_valid is 0, all captured outputs are 0, and the automatic phase of both groups is 4. This means cur_phase and cur_phase_sync read 4 whenever auto_en is 1 before any window has completed.
- R2: out_valid pulses for exactly one cycle, in the cycle after a pix_stb. It pulses only if all eight samples of the preceding period were taken after reset. The first strobe after reset therefore yields no valid pulse.
- R3: The fast cycle in which pix_stb is high is phase 0, and the following cycles are phases 1 to 7. On each strobe the outputs take the colour sample from phase cur_phase of the period just ended, and they hold that value until the next strobe.
- R4: With SPLIT_GROUPS=1, hs_out, vs_out and de_out take their sample from phase cur_phase_sync. In manual mode that phase is man_phase_sync, independently of the colour phase.
- R5: In automatic mode, suppose the colour bits change at position t in every period of two consecutive windows of win_len strobes. The colour phase then becomes (t+4) mod 8.
- R6: A new automatic choice is adopted only if the previous window produced the same choice. Windows whose choices keep alternating leave the phase unchanged.
- R7: With SPLIT_GROUPS=1, the sync/enable group runs its own automatic search from its own transitions, independently of the colour group.
- R8: A window in which no monitored input changes leaves the automatic phase unchanged.
- R9: When auto_en is 0, cur_phase equals man_phase and cur_phase_sync equals man_phase_sync. Clearing auto_en returns the block to manual selection in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, 8x pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_stb | input | 1 | High for one fast cycle at phase 0 of each pixel period |
| rgb_in | input | 12 | Raw colour bus, {R,G,B} 4 bits each |
| hs_in | input | 1 | Raw horizontal sync |
| vs_in | input | 1 | Raw vertical sync |
| de_in | input | 1 | Raw display enable |
| auto_en | input | 1 | 1 = automatic sweet-spot search, 0 = manual phase |
| man_phase | input | 3 | Manual phase for the colour group |
| man_phase_sync | input | 3 | Manual phase for the sync/enable group |
| win_len | input | 16 | Search window length in pixel periods (0 acts as 1) |
| rgb_out | output | 12 | Captured colour |
| hs_out | output | 1 | Captured horizontal sync |
| vs_out | output | 1 | Captured vertical sync |
| de_out | output | 1 | Captured display enable |
| out_valid | output | 1 | One-cycle pulse when new captured values appear |
| cur_phase | output | 3 | Phase in use for the colour group |
| cur_phase_sync | output | 3 | Phase in use for the sync/enable group |

## Verification
On every cycle, the embedded properties check four things. The valid pulse follows a strobe and never lasts two cycles. The captured colour never moves between strobes. The automatic phases start at 4 and change only at a window boundary. Whether the correct sample is forwarded for each phase and skew, and whether the search ends up opposite the busiest edge, depend on real data patterns. So do the refusal to switch on alternating choices and the holding of the phase on idle input. Only the bench's scenarios can show these, because they drive periods with a known edge position and compare the captured values with what that position predicts.

// File: rtl/vid_phase_capture.sv
module vid_phase_capture #(
  parameter int RGB_W        = 12,
  parameter int NPH          = 8,
  parameter int WIN_W        = 16,
  parameter int CNT_W        = 12,
  parameter int SPLIT_GROUPS = 1,
  localparam int PH_W        = $clog2(NPH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_stb,
  input  logic [RGB_W-1:0] rgb_in,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic             de_in,
  input  logic             auto_en,
  input  logic [PH_W-1:0]  man_phase,
  input  logic [PH_W-1:0]  man_phase_sync,
  input  logic [WIN_W-1:0] win_len,
  output logic [RGB_W-1:0] rgb_out,
  output logic             hs_out,
  output logic             vs_out,
  output logic             de_out,
  output logic             out_valid,
  output logic [PH_W-1:0]  cur_phase,
  output logic [PH_W-1:0]  cur_phase_sync
);
  localparam int NG = (SPLIT_GROUPS != 0) ? 2 : 1;
  localparam logic [PH_W-1:0] HALF = PH_W'(NPH / 2);

  logic [2:0]       sync_in;
  logic [PH_W-1:0]  pos_q, pos_d;
  logic [RGB_W-1:0] rgb_smp [NPH];
  logic [2:0]       sync_smp [NPH];
  logic             started_q, full_q;
  logic [RGB_W-1:0] last_rgb;
  logic [2:0]       last_sync;
  logic             t_rgb, t_sync;
  logic [NG-1:0]    hit;
  logic [WIN_W-1:0] win_q;
  logic [WIN_W:0]   win_nx;
  logic             win_end;
  logic [PH_W-1:0]  aph [NG];

  assign sync_in = {hs_in, vs_in, de_in};
  assign pos_d   = pix_stb ? '0 : ((pos_q == PH_W'(NPH - 1)) ? pos_q : pos_q + 1'b1);
  assign t_rgb   = |(rgb_in ^ last_rgb);
  assign t_sync  = |(sync_in ^ last_sync);
  assign win_nx  = {1'b0, win_q} + 1'b1;
  assign win_end = auto_en && pix_stb && (win_nx >= {1'b0, win_len});

  generate
    if (NG == 2) begin : g_hit2
      assign hit = {t_sync, t_rgb};
    end else begin : g_hit1
      assign hit = t_rgb | t_sync;
    end
  endgenerate

  assign cur_phase      = auto_en ? aph[0] : man_phase;
  assign cur_phase_sync = auto_en ? aph[NG-1]
                        : ((SPLIT_GROUPS != 0) ? man_phase_sync : man_phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q     <= PH_W'(NPH - 1);
      started_q <= 1'b0;
      full_q    <= 1'b0;
      last_rgb  <= '0;
      last_sync <= '0;
      for (int k = 0; k < NPH; k++) begin
        rgb_smp[k]  <= '0;
        sync_smp[k] <= '0;
      end
    end else begin
      pos_q          <= pos_d;
      last_rgb       <= rgb_in;
      last_sync      <= sync_in;
      rgb_smp[pos_d] <= rgb_in;
      sync_smp[pos_d] <= sync_in;
      if (pix_stb) begin
        started_q <= 1'b1;
        full_q    <= 1'b0;
      end else if (started_q && pos_d == PH_W'(NPH - 1)) begin
        full_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rgb_out   <= '0;
      hs_out    <= 1'b0;
      vs_out    <= 1'b0;
      de_out    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= pix_stb && full_q;
      if (pix_stb) begin
        rgb_out                  <= rgb_smp[cur_phase];
        {hs_out, vs_out, de_out} <= sync_smp[cur_phase_sync];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !auto_en) win_q <= '0;
    else if (pix_stb)       win_q <= win_end ? '0 : win_q + 1'b1;
  end

  generate
    for (genvar g = 0; g < NG; g++) begin : g_grp
      logic [CNT_W-1:0] cnt [NPH];
      logic [CNT_W-1:0] bmax;
      logic [PH_W-1:0]  bidx, cand, prev_c;
      logic             prev_v;

      always_comb begin
        bmax = cnt[0];
        bidx = '0;
        for (int k = 1; k < NPH; k++) begin
          if (cnt[k] > bmax) begin
            bmax = cnt[k];
            bidx = PH_W'(k);
          end
        end
        cand = bidx + HALF;
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int k = 0; k < NPH; k++) cnt[k] <= '0;
          aph[g] <= HALF;
          prev_c <= '0;
          prev_v <= 1'b0;
        end else if (!auto_en) begin
          for (int k = 0; k < NPH; k++) cnt[k] <= '0;
          prev_v <= 1'b0;
        end else begin
          for (int k = 0; k < NPH; k++) begin
            if (win_end)
              cnt[k] <= (hit[g] && pos_d == PH_W'(k)) ? CNT_W'(1) : '0;
            else if (hit[g] && pos_d == PH_W'(k) && cnt[k] != '1)
              cnt[k] <= cnt[k] + 1'b1;
          end
          if (win_end) begin
            if (bmax != '0) begin
              prev_c <= cand;
              prev_v <= 1'b1;
              if (prev_v && prev_c == cand) aph[g] <= cand;
            end else begin
              prev_v <= 1'b0;
            end
          end
        end
      end

      AST_APH_RESET:    assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> aph[g] == HALF); // R1
      AST_APH_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(aph[g]) |-> $past(win_end)); // R6
    end
  endgenerate

  AST_VALID_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid); // R2
  AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(pix_stb)); // R2
  AST_OUT_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) !$past(pix_stb) |-> $stable(rgb_out)); // R3
endmodule

// File: tb/tb_vid_phase_capture.sv
module tb_vid_phase_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_stb = 1'b0;
  logic [11:0] rgb_in = '0;
  logic        hs_in = 1'b0, vs_in = 1'b0, de_in = 1'b0;
  logic        auto_en = 1'b0;
  logic [2:0]  man_phase = '0, man_phase_sync = '0;
  logic [15:0] win_len = 16'd4;
  logic [11:0] rgb_out;
  logic        hs_out, vs_out, de_out, out_valid;
  logic [2:0]  cur_phase, cur_phase_sync;

  int checks = 0, fails = 0;
  int obs_rgb, obs_sync, obs_v1, obs_v2;
  int p = 0;

  always #4 clk = ~clk;

  vid_phase_capture dut (
    .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .rgb_in(rgb_in),
    .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in), .auto_en(auto_en),
    .man_phase(man_phase), .man_phase_sync(man_phase_sync), .win_len(win_len),
    .rgb_out(rgb_out), .hs_out(hs_out), .vs_out(vs_out), .de_out(de_out),
    .out_valid(out_valid), .cur_phase(cur_phase), .cur_phase_sync(cur_phase_sync));

  // {man_phase, man_phase_sync, rgb edge pos, sync edge pos, rgb offset, sync offset}
  localparam int VEC [8][6] = '{
    '{0, 7, 1, 7, 0, 1}, '{1, 0, 1, 1, 1, 0}, '{7, 3, 7, 4, 1, 0}, '{4, 4, 5, 4, 0, 1},
    '{5, 2, 3, 6, 1, 0}, '{3, 5, 3, 5, 1, 1}, '{6, 1, 7, 2, 0, 0}, '{2, 2, 2, 3, 1, 0}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one pixel period: value q before edge position, q+1 from it on
  task automatic drive_period(input int q, input int pr, input int ps);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k == 1) begin
        obs_rgb  = int'(rgb_out);
        obs_sync = int'({hs_out, vs_out, de_out});
        obs_v1   = int'(out_valid);
      end
      if (k == 2) obs_v2 = int'(out_valid);
      pix_stb = (k == 0);
      rgb_in  = 12'((k >= pr) ? q + 1 : q);
      {hs_in, vs_in, de_in} = 3'((k >= ps) ? q + 1 : q);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    auto_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 rgb_out", int'(rgb_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 auto phase rgb", int'(cur_phase), 4);
    chk("R1 auto phase sync", int'(cur_phase_sync), 4);
    auto_en = 1'b0;
    man_phase = 3'd2;
    man_phase_sync = 3'd6;
    drive_period(0, 3, 5);
    chk("R2 no valid after first strobe", obs_v1, 0);
    drive_period(1, 3, 5);
    chk("R2 valid pulse", obs_v1, 1);
    chk("R2 valid one cycle", obs_v2, 0);
    chk("R3 rgb phase2", obs_rgb, 0);
    chk("R4 sync phase6", obs_sync, 1);
    p = 2;

    foreach (VEC[i]) begin
      man_phase = 3'(VEC[i][0]);
      man_phase_sync = 3'(VEC[i][1]);
      drive_period(p, VEC[i][2], VEC[i][3]);
      drive_period(p + 1, VEC[i][2], VEC[i][3]);
      chk("R3 manual rgb", obs_rgb, (p + VEC[i][4]) & 12'hfff);
      chk("R4 manual sync", obs_sync, (p + VEC[i][5]) & 7);
      chk("R9 cur_phase", int'(cur_phase), VEC[i][0]);
      chk("R9 cur_phase_sync", int'(cur_phase_sync), VEC[i][1]);
      p += 2;
    end

    // automatic: rgb edge at 2 -> 6, sync edge at 5 -> 1
    man_phase = 3'd0;
    man_phase_sync = 3'd0;
    auto_en = 1'b1;
    for (int n = 0; n < 4; n++) begin drive_period(p, 2, 5); p++; end
    chk("R5 one window not enough", int'(cur_phase), 4);
    for (int n = 0; n < 4; n++) begin drive_period(p, 2, 5); p++; end
    chk("R5 auto rgb phase", int'(cur_phase), 6);
    chk("R7 auto sync phase", int'(cur_phase_sync), 1);
    for (int n = 0; n < 3; n++) begin drive_period(p, 2, 5); p++; end
    drive_period(p, 2, 5);
    chk("R5 captured at phase6", obs_rgb, p & 12'hfff);
    chk("R7 captured sync at phase1", obs_sync, (p - 1) & 7);
    p++;

    // alternating choices 5,7,5,7 must not move the phase
    for (int w = 0; w < 4; w++)
      for (int n = 0; n < 4; n++) begin
        drive_period(p, (w % 2 == 0) ? 1 : 3, 5);
        p++;
      end
    drive_period(p, 1, 5);
    chk("R6 hysteresis rgb", int'(cur_phase), 6);
    chk("R6 sync unaffected", int'(cur_phase_sync), 1);

    // idle input: no transitions anywhere
    for (int n = 0; n < 12; n++) drive_period(p + 1, 8, 8);
    chk("R8 idle rgb phase", int'(cur_phase), 6);
    chk("R8 idle sync phase", int'(cur_phase_sync), 1);

    man_phase = 3'd3;
    man_phase_sync = 3'd5;
    auto_en = 1'b0;
    #1;
    chk("R9 back to manual", int'(cur_phase), 3);
    chk("R9 back to manual sync", int'(cur_phase_sync), 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule